// File: doc/BRIEF.md
# Interleaved Doorbell Interrupt Controller

This block lets processors on a chip signal one another. It holds several instances. Each instance is a bank of single-bit channels, and every channel carries two state bits: an armed (enable) bit and a raised (pending) bit. A sending processor rings a channel by setting its raised bit. The instance's interrupt line then goes toward the receiving processor, provided that channel is armed. The receiver acknowledges the channel by clearing the raised bit.

Software never writes the state words directly. Each state word can be changed only through a pair of strobe registers, one that sets bits and one that clears them. Writing a 1 touches only that channel, and writing a 0 touches nothing. The state is read back through value registers. The registers of all instances share one address map. Within each register group, instance n sits at the group's base plus 4*n, so the instances are interleaved group by group. Each channel also drives a ready flag that is high only when the channel is armed and not yet raised, meaning a sender may ring it.

Top module: `doorbell_ctrl`

## Requirements
- R1: After reset every raised and armed bit is 0, every interrupt line is 0, every ready flag is 0 and every mapped register reads 0.
- R2: A write to the raise-set register (byte offset 0x24 + 4*n) sets, in instance n only, the raised bits at the 1 positions of the written word. The 0 positions and all other instances keep their values.
- R3: A write to the raise-clear register (0x44 + 4*n) clears, in instance n only, the raised bits at the 1 positions. All other bits keep their values.
- R4: A write to the arm-set register (0x84 + 4*n) sets armed bits, and a write to the arm-clear register (0xA4 + 4*n) clears armed bits. Both act per 1 bit and only in instance n.
- R5: A read issued in one cycle presents its word on rdata after the next rising edge. The raised word of instance n reads at 0x04, 0x24 and 0x44 (+4*n), and the armed word reads at 0x64, 0x84 and 0xA4 (+4*n).
- R6: Writes to the value registers (0x04 + 4*n and 0x64 + 4*n) change no state.
- R7: An offset that is not one of the 24 mapped words reads as 0 and ignores writes. This covers 0x00, the gaps between groups, offsets past 0xB0 and any offset that is not a multiple of 4.
- R8: Interrupt line n is 1 exactly when some channel of instance n was both raised and armed at the previous rising edge. It therefore changes one cycle after the state does.
- R9: Ready flag n*32+c is 1 exactly when channel c of instance n is armed and not raised. It follows the state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data, one bit per channel |
| rdata | output | 32 | Read data, valid the cycle after rd_en, 0 otherwise |
| irq | output | 4 | One registered interrupt line per instance |
| tx_ready | output | 128 | Per-channel ready flag, instance n at bits n*32 to n*32+31 |

## Verification
The bench works the interleaving hard. It writes to one instance and then reads the same group for the neighbouring instances. A decoder that mixed up the per-instance stride would show the write in the wrong word. It writes all-ones to the value registers, to the gaps between groups, to 0x00 and to offsets that are not word aligned, then reads the state back. A decoder that matched too loosely would corrupt a bank. It writes zero words to the set and clear strobes. A design that copied the word instead of acting per bit would wipe the state. It samples the interrupt in the cycle right after the ringing write and again one cycle later. An unregistered output, or one that is two cycles late, fails one of those two samples. A channel that is raised but not armed must keep the line low.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  // Register groups in address order; the order fixes each group's base.
  typedef enum logic [2:0] {
    GRP_RAISE_VAL = 3'd0,
    GRP_RAISE_SET = 3'd1,
    GRP_RAISE_CLR = 3'd2,
    GRP_ARM_VAL   = 3'd3,
    GRP_ARM_SET   = 3'd4,
    GRP_ARM_CLR   = 3'd5
  } grp_e;

  localparam int unsigned NGRP       = 6;
  localparam int unsigned GRP_FIRST  = 4;   // byte offset of group 0
  localparam int unsigned GRP_STRIDE = 32;  // bytes between group bases

  function automatic int unsigned grp_base(int unsigned g);
    return GRP_FIRST + g * GRP_STRIDE;
  endfunction

  // Groups whose words read back the raised state.
  function automatic bit grp_reads_raise(int unsigned g);
    return g <= 2;
  endfunction

endpackage

// File: rtl/doorbell_regdec.sv
module doorbell_regdec
  import doorbell_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_INST = 4,
  localparam int unsigned IW      = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NGRP-1:0]   grp_hit,
  output logic              mapped,
  output logic [IW-1:0]     inst
);

  localparam int unsigned SPAN = NUM_INST * 4;

  logic [ADDR_W-1:0] rel [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign rel[g]     = addr - ADDR_W'(grp_base(g));
    assign grp_hit[g] = (rel[g] < ADDR_W'(SPAN)) && (rel[g][1:0] == 2'b00);
  end

  always_comb begin
    inst = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_hit[g]) inst = rel[g][IW+1:2];
    end
  end

  assign mapped = |grp_hit;

endmodule

// File: rtl/doorbell_bank.sv
module doorbell_bank #(
  parameter int unsigned NUM_CHAN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                raise_set_we,
  input  logic                raise_clr_we,
  input  logic                arm_set_we,
  input  logic                arm_clr_we,
  input  logic [NUM_CHAN-1:0] wmask,
  output logic [NUM_CHAN-1:0] raised,
  output logic [NUM_CHAN-1:0] armed,
  output logic                irq
);

  // Per-bit update: clear first, then set, so a set always wins.
  function automatic logic [NUM_CHAN-1:0] strobe_update(
    input logic [NUM_CHAN-1:0] cur,
    input logic [NUM_CHAN-1:0] set_m,
    input logic [NUM_CHAN-1:0] clr_m
  );
    return (cur & ~clr_m) | set_m;
  endfunction

  logic [NUM_CHAN-1:0] raise_set_m, raise_clr_m, arm_set_m, arm_clr_m;
  logic                live;

  assign raise_set_m = raise_set_we ? wmask : '0;
  assign raise_clr_m = raise_clr_we ? wmask : '0;
  assign arm_set_m   = arm_set_we   ? wmask : '0;
  assign arm_clr_m   = arm_clr_we   ? wmask : '0;
  assign live        = |(raised & armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raised <= '0;
      armed  <= '0;
      irq    <= 1'b0;
    end else begin
      raised <= strobe_update(raised, raise_set_m, raise_clr_m);
      armed  <= strobe_update(armed, arm_set_m, arm_clr_m);
      irq    <= live;
    end
  end

endmodule

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_INST = 4,
  parameter int unsigned NUM_CHAN = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NUM_CHAN-1:0]          wdata,
  output logic [NUM_CHAN-1:0]          rdata,
  output logic [NUM_INST-1:0]          irq,
  output logic [NUM_INST*NUM_CHAN-1:0] tx_ready
);

  localparam int unsigned IW = (NUM_INST > 1) ? $clog2(NUM_INST) : 1;

  // Named decode events, brought out for the checker.
  logic [NGRP-1:0]              grp_hit;
  logic                         mapped;
  logic [IW-1:0]                inst_sel;
  logic                         reads_raise;
  logic [NUM_CHAN-1:0]          rd_word;
  logic [NUM_INST*NUM_CHAN-1:0] raised_flat;
  logic [NUM_INST*NUM_CHAN-1:0] armed_flat;
  logic [NUM_CHAN-1:0]          raised_arr [NUM_INST];
  logic [NUM_CHAN-1:0]          armed_arr  [NUM_INST];

  doorbell_regdec #(
    .ADDR_W   (ADDR_W),
    .NUM_INST (NUM_INST)
  ) u_dec (
    .addr    (addr),
    .grp_hit (grp_hit),
    .mapped  (mapped),
    .inst    (inst_sel)
  );

  for (genvar n = 0; n < NUM_INST; n++) begin : g_inst
    logic sel;
    assign sel = wr_en && mapped && (inst_sel == IW'(n));

    doorbell_bank #(
      .NUM_CHAN (NUM_CHAN)
    ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .raise_set_we (sel && grp_hit[int'(GRP_RAISE_SET)]),
      .raise_clr_we (sel && grp_hit[int'(GRP_RAISE_CLR)]),
      .arm_set_we   (sel && grp_hit[int'(GRP_ARM_SET)]),
      .arm_clr_we   (sel && grp_hit[int'(GRP_ARM_CLR)]),
      .wmask        (wdata),
      .raised       (raised_arr[n]),
      .armed        (armed_arr[n]),
      .irq          (irq[n])
    );

    assign raised_flat[n*NUM_CHAN +: NUM_CHAN] = raised_arr[n];
    assign armed_flat[n*NUM_CHAN +: NUM_CHAN]  = armed_arr[n];
    assign tx_ready[n*NUM_CHAN +: NUM_CHAN]    = armed_arr[n] & ~raised_arr[n];
  end

  always_comb begin
    reads_raise = 1'b0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_hit[g] && grp_reads_raise(g)) reads_raise = 1'b1;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int n = 0; n < NUM_INST; n++) begin
      if (mapped && inst_sel == IW'(n))
        rd_word = reads_raise ? raised_arr[n] : armed_arr[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_word : '0;
  end

endmodule

// File: rtl/doorbell_ctrl_chk.sv
module doorbell_ctrl_chk
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_INST = 4,
  parameter int unsigned NUM_CHAN = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic                         rd_en,
  input logic [ADDR_W-1:0]            addr,
  input logic [NUM_CHAN-1:0]          rdata,
  input logic [NUM_INST-1:0]          irq,
  input logic [NUM_INST*NUM_CHAN-1:0] tx_ready,
  input logic [NUM_INST*NUM_CHAN-1:0] raised_flat,
  input logic [NUM_INST*NUM_CHAN-1:0] armed_flat,
  input logic [NGRP-1:0]              grp_hit
);

  function automatic bit in_group(logic [ADDR_W-1:0] a, int unsigned g);
    int unsigned ai;
    ai = int'(a);
    return (ai >= grp_base(g)) && (ai < grp_base(g) + 4 * NUM_INST) && (a[1:0] == 2'b00);
  endfunction

  logic is_rset, is_rclr, is_state_wr, is_unmapped;
  logic [NUM_INST-1:0] live;

  assign is_rset     = in_group(addr, 1);
  assign is_rclr     = in_group(addr, 2);
  assign is_state_wr = in_group(addr, 1) || in_group(addr, 2) || in_group(addr, 4) || in_group(addr, 5);
  assign is_unmapped = !(is_state_wr || in_group(addr, 0) || in_group(addr, 3));

  for (genvar n = 0; n < NUM_INST; n++) begin : g_live
    assign live[n] = |(raised_flat[n*NUM_CHAN +: NUM_CHAN] & armed_flat[n*NUM_CHAN +: NUM_CHAN]);
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (raised_flat == '0) && (armed_flat == '0) && (irq == '0));

  a_r2_raise_only_by_set: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && is_rset) |=> ((raised_flat & ~$past(raised_flat)) == '0));

  a_r3_drop_only_by_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && is_rclr) |=> (($past(raised_flat) & ~raised_flat) == '0));

  a_r6_r7_no_state_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_state_wr) |=> (raised_flat == $past(raised_flat)) && (armed_flat == $past(armed_flat)));

  a_r7_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_unmapped) |=> (rdata == '0));

  a_r7_decode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_hit));

  a_r8_irq_one_cycle_late: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(live)));

  a_r9_ready_not_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready & raised_flat) == '0);

  a_r9_ready_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready & ~armed_flat) == '0);

endmodule

bind doorbell_ctrl doorbell_ctrl_chk #(
  .NUM_INST (NUM_INST),
  .NUM_CHAN (NUM_CHAN),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .rdata       (rdata),
  .irq         (irq),
  .tx_ready    (tx_ready),
  .raised_flat (raised_flat),
  .armed_flat  (armed_flat),
  .grp_hit     (grp_hit)
);

// File: tb/doorbell_ctrl_bench.sv
module doorbell_ctrl_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [3:0]   irq;
  logic [127:0] tx_ready;

  int total = 0;
  int bad   = 0;

  logic [31:0] m_raise [4];
  logic [31:0] m_arm   [4];

  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit          rd_pend = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  doorbell_ctrl u_doorbell_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq      (irq),
    .tx_ready (tx_ready)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model of the register map written from the requirements.
  function automatic bit slot(input logic [7:0] a, input logic [7:0] base, output int idx);
    idx = int'((a - base) >> 2);
    return (a >= base) && (a <= base + 8'h0C) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int i;
    if (slot(a, 8'h04, i) || slot(a, 8'h24, i) || slot(a, 8'h44, i)) return m_raise[i];
    if (slot(a, 8'h64, i) || slot(a, 8'h84, i) || slot(a, 8'hA4, i)) return m_arm[i];
    return 32'h0;
  endfunction

  function automatic logic [3:0] model_irq();
    logic [3:0] v;
    for (int n = 0; n < 4; n++) v[n] = |(m_raise[n] & m_arm[n]);
    return v;
  endfunction

  function automatic logic [127:0] model_ready();
    logic [127:0] v;
    for (int n = 0; n < 4; n++) v[n*32 +: 32] = m_arm[n] & ~m_raise[n];
    return v;
  endfunction

  // Driver tasks: entered and left at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int i;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (slot(a, 8'h24, i)) m_raise[i] = m_raise[i] | d;
    if (slot(a, 8'h44, i)) m_raise[i] = m_raise[i] & ~d;
    if (slot(a, 8'h84, i)) m_arm[i]   = m_arm[i] | d;
    if (slot(a, 8'hA4, i)) m_arm[i]   = m_arm[i] & ~d;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int g = 0; g < 6; g++)
      for (int n = 0; n < 4; n++)
        rd(8'(8'h04 + g * 8'h20 + n * 4), tag);
  endtask

  // Monitor: the word requested at one edge is compared at the next falling edge.
  always @(posedge clk) rd_pend <= rd_en;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R5 unexpected read result actual=%h expected=none", rdata);
      end else begin
        chk(tag_q.pop_front(), {96'h0, rdata}, {96'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] irq_before;
    for (int n = 0; n < 4; n++) begin m_raise[n] = '0; m_arm[n] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq after reset", {124'h0, irq}, 128'h0);
    chk("R1 tx_ready after reset", tx_ready, 128'h0);
    sweep("R1 R5 register after reset");

    // R4: arm instance 0 upper half and instance 2 low byte
    wr(8'h84, 32'hFFFF_0000);
    wr(8'h8C, 32'h0000_00FF);
    rd(8'h64, "R4 R5 arm value inst0");
    rd(8'h84, "R5 arm set readback inst0");
    rd(8'hA4, "R5 arm clear readback inst0");
    rd(8'h68, "R4 neighbour inst1 untouched");
    rd(8'h6C, "R4 arm value inst2");
    chk("R9 ready after arming", tx_ready, model_ready());
    chk("R8 irq with nothing raised", {124'h0, irq}, 128'h0);

    // R2/R8: raise one armed and one unarmed channel in instance 0
    wr(8'h24, 32'h0001_0001);
    chk("R9 ready same cycle as raise", tx_ready, model_ready());
    chk("R8 irq not yet on the write cycle", {124'h0, irq}, 128'h0);
    @(negedge clk);
    chk("R8 irq one cycle after raise", {124'h0, irq}, {124'h0, model_irq()});
    chk("R8 irq0 expected high", {127'h0, irq[0]}, 128'h1);

    // R2/R8: raise unarmed channel in instance 1: line stays low
    wr(8'h28, 32'h8000_0000);
    @(negedge clk);
    chk("R8 raised but unarmed keeps line low", {124'h0, irq}, 128'h1);
    rd(8'h08, "R2 raise value inst1");
    rd(8'h04, "R2 raise value inst0 unaffected");
    wr(8'h30, 32'h0);
    rd(8'h10, "R2 zero word to set has no effect");

    // R6: value registers ignore writes
    wr(8'h04, 32'h0);
    wr(8'h6C, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF);
    rd(8'h04, "R6 raise value write ignored");
    rd(8'h6C, "R6 arm value write ignored");
    rd(8'h70, "R6 arm value inst3 write ignored");

    // R7: unmapped offsets
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'hC4, 32'hFFFF_FFFF);
    wr(8'h26, 32'hFFFF_FFFF);
    wr(8'hA5, 32'hFFFF_FFFF);
    rd(8'h00, "R7 read 0x00");
    rd(8'h14, "R7 read gap 0x14");
    rd(8'h26, "R7 read misaligned 0x26");
    rd(8'hFC, "R7 read 0xFC");
    chk("R7 ready unchanged after unmapped writes", tx_ready, model_ready());
    sweep("R7 state intact after unmapped writes");

    // R3/R8: clear the armed raised channel, line falls a cycle later
    wr(8'h44, 32'h0);
    rd(8'h04, "R3 zero word to clear has no effect");
    irq_before = irq;
    wr(8'h44, 32'h0001_0000);
    chk("R8 irq holds on the clear cycle", {124'h0, irq}, {124'h0, irq_before});
    @(negedge clk);
    chk("R3 R8 irq after clear", {124'h0, irq}, {124'h0, model_irq()});
    rd(8'h04, "R3 raise value after clear");

    // R2/R8: ring instance 2, then disarm it
    wr(8'h2C, 32'h0000_0008);
    @(negedge clk);
    chk("R8 irq2 after raise", {124'h0, irq}, {124'h0, model_irq()});
    wr(8'hAC, 32'h0000_000F);
    chk("R4 R9 ready after arm clear", tx_ready, model_ready());
    @(negedge clk);
    chk("R4 R8 irq after disarm", {124'h0, irq}, {124'h0, model_irq()});
    wr(8'hA4, 32'h0000_0001);
    rd(8'hA4, "R4 arm clear inst0 bit0");

    sweep("R5 final register sweep");
    @(negedge clk);
    chk("R9 final ready", tx_ready, model_ready());
    chk("R5 all reads answered", 128'(exp_q.size()), 128'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule